// File: doc/BRIEF.md
# Set-Compare and Conditional-Move Unit

This execute-stage unit handles two instruction families of a 32-bit load/store processor. The first is the compares. Each compare tests two operands and produces a boolean word: 1 when its condition is true and 0 when it is false. That word is written to the destination register. The second operand comes either from register B or from a sign-extended 16-bit immediate. The second family is the conditional moves. A conditional move copies register A to the destination only when register B is zero (move-if-zero) or only when it is nonzero (move-if-nonzero). When the condition fails, the unit drops the register write.

The unit receives the following inputs:
- a 4-bit operation code;
- both source operands;
- the immediate and an immediate-select bit;
- the current destination value.

It returns the value to write and a write-enable. Both outputs are registered one clock after the inputs are presented. Decode, forwarding and the register file lie outside this unit.

Top module: `set_cmp_cmov`

## Requirements
- R1: Each compare operation (codes 0 to 3) produces a result whose bits above bit 0 are all zero, and it always asserts the write-enable.
- R2: Code 0 (equal) gives result 1 when A equals the second operand, and 0 otherwise.
- R3: Code 1 (not-equal) gives result 1 when A differs from the second operand, and 0 otherwise.
- R4: Code 2 (signed less-than) gives result 1 when A is less than the second operand, with both read as two's-complement numbers.
- R5: Code 3 (unsigned less-than) gives result 1 when A is less than the second operand, with both read as unsigned numbers.
- R6: For codes 0 to 3, immediate-select high replaces the second operand with the 16-bit immediate sign-extended to 32 bits. Immediate-select low uses register B.
- R7: Code 4 (move-if-zero) behaves as follows:
  - When B is zero, the result is A and the write-enable is high.
  - Otherwise, the write-enable is low and the result equals the old destination value.
- R8: Code 5 (move-if-nonzero) behaves as follows:
  - When B is nonzero, the result is A and the write-enable is high.
  - Otherwise, the write-enable is low and the result equals the old destination value.
- R9: The conditional moves ignore immediate-select and the immediate, and always test register B.
- R10: Codes 6 to 15 give a low write-enable and a zero result.
- R11: Result and write-enable change only on a rising clock edge, one cycle after their inputs. A synchronous active-high reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| src_a_i | input | 32 | Source operand A |
| src_b_i | input | 32 | Source operand B |
| imm_i | input | 16 | Immediate field |
| imm_sel_i | input | 1 | Compare uses the immediate instead of B |
| old_dst_i | input | 32 | Current destination register value |
| result_o | output | 32 | Registered value to write |
| wr_en_o | output | 1 | Registered destination write-enable |

## Verification
The bench builds the unit with its default widths: 32-bit data and a 16-bit immediate. This keeps the sign-extension boundary and the full signed and unsigned ranges in play. It sweeps all sixteen operation codes and both immediate-select settings. Each of these is crossed with a set of corner operand values: zero, one, all-ones, the most positive and most negative values, and ordinary patterns. The immediate also takes corner values, including 0x8000 and 0x7FFF. Together these reach every compare outcome, both sides of each conditional move, and every unsupported code, and the bench computes each expected value arithmetically.

// File: rtl/scm_pkg.sv
package scm_pkg;

    localparam int OP_W = 4;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'd0,
        CMP_NE  = 2'd1,
        CMP_LTS = 2'd2,
        CMP_LTU = 2'd3
    } cmp_kind_e;

    localparam logic [OP_W-1:0] OP_SEQ  = 4'd0;
    localparam logic [OP_W-1:0] OP_SNE  = 4'd1;
    localparam logic [OP_W-1:0] OP_SLT  = 4'd2;
    localparam logic [OP_W-1:0] OP_SLTU = 4'd3;
    localparam logic [OP_W-1:0] OP_MOVZ = 4'd4;
    localparam logic [OP_W-1:0] OP_MOVN = 4'd5;

    typedef struct packed {
        logic      is_cmp;
        logic      is_cmov;
        logic      use_imm;
        cmp_kind_e kind;
        logic      move_on_zero;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [OP_W-1:0] op, input logic imm_sel);
        ctl_t c;
        c = '{is_cmp: 1'b0, is_cmov: 1'b0, use_imm: 1'b0,
              kind: CMP_EQ, move_on_zero: 1'b0};
        case (op)
            OP_SEQ:  begin c.is_cmp = 1'b1; c.kind = CMP_EQ;  end
            OP_SNE:  begin c.is_cmp = 1'b1; c.kind = CMP_NE;  end
            OP_SLT:  begin c.is_cmp = 1'b1; c.kind = CMP_LTS; end
            OP_SLTU: begin c.is_cmp = 1'b1; c.kind = CMP_LTU; end
            OP_MOVZ: begin c.is_cmov = 1'b1; c.move_on_zero = 1'b1; end
            OP_MOVN: begin c.is_cmov = 1'b1; c.move_on_zero = 1'b0; end
            default: ;
        endcase
        c.use_imm = c.is_cmp & imm_sel;
        return c;
    endfunction

endpackage

// File: rtl/scm_operand_sel.sv
module scm_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] reg_b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    output logic [DATA_W-1:0] opnd_o
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        end else begin : g_trunc
            assign imm_ext = imm_i[DATA_W-1:0];
        end
    endgenerate

    assign opnd_o = use_imm_i ? imm_ext : reg_b_i;
endmodule

// File: rtl/scm_compare.sv
module scm_compare
    import scm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs_i,
    input  logic [DATA_W-1:0] rhs_i,
    input  cmp_kind_e         kind_i,
    output logic              hit_o
);
    logic same, below_u, below_s;

    assign same    = (lhs_i == rhs_i);
    assign below_u = (lhs_i < rhs_i);
    assign below_s = ($signed(lhs_i) < $signed(rhs_i));

    always_comb begin
        case (kind_i)
            CMP_EQ:  hit_o = same;
            CMP_NE:  hit_o = ~same;
            CMP_LTS: hit_o = below_s;
            CMP_LTU: hit_o = below_u;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/scm_cmove.sv
module scm_cmove #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] test_i,
    input  logic [DATA_W-1:0] keep_i,
    input  logic              on_zero_i,
    output logic [DATA_W-1:0] data_o,
    output logic              take_o
);
    logic test_zero;

    assign test_zero = (test_i == '0);
    assign take_o    = on_zero_i ? test_zero : ~test_zero;
    assign data_o    = take_o ? src_i : keep_i;
endmodule

// File: rtl/set_cmp_cmov.sv
module set_cmp_cmov
    import scm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              imm_sel_i,
    input  logic [DATA_W-1:0] old_dst_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o
);
    ctl_t              ctl;
    logic [DATA_W-1:0] opnd_b;
    logic              cmp_hit;
    logic [DATA_W-1:0] mv_data;
    logic              mv_take;
    logic [DATA_W-1:0] nxt_res;
    logic              nxt_we;

    assign ctl = decode_op(op_i, imm_sel_i);

    scm_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .reg_b_i   (src_b_i),
        .imm_i     (imm_i),
        .use_imm_i (ctl.use_imm),
        .opnd_o    (opnd_b)
    );

    scm_compare #(.DATA_W(DATA_W)) u_cmp (
        .lhs_i  (src_a_i),
        .rhs_i  (opnd_b),
        .kind_i (ctl.kind),
        .hit_o  (cmp_hit)
    );

    scm_cmove #(.DATA_W(DATA_W)) u_mov (
        .src_i     (src_a_i),
        .test_i    (src_b_i),
        .keep_i    (old_dst_i),
        .on_zero_i (ctl.move_on_zero),
        .data_o    (mv_data),
        .take_o    (mv_take)
    );

    always_comb begin
        nxt_res = '0;
        nxt_we  = 1'b0;
        if (ctl.is_cmp) begin
            nxt_res = {{(DATA_W-1){1'b0}}, cmp_hit};
            nxt_we  = 1'b1;
        end else if (ctl.is_cmov) begin
            nxt_res = mv_data;
            nxt_we  = mv_take;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            wr_en_o  <= 1'b0;
        end else begin
            result_o <= nxt_res;
            wr_en_o  <= nxt_we;
        end
    end
endmodule

// File: rtl/scm_checker.sv
module scm_checker
    import scm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] src_a_i,
    input logic [DATA_W-1:0] src_b_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o
);
    logic op_cmp;
    assign op_cmp = (op_i <= OP_SLTU);

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (result_o == '0 && !wr_en_o));

    assert_cmp_boolean_R1: assert property (@(posedge clk) disable iff (rst)
        op_cmp |=> (result_o[DATA_W-1:1] == '0 && wr_en_o));

    assert_movz_take_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_MOVZ && src_b_i == '0) |=> (wr_en_o && result_o == $past(src_a_i)));

    assert_movz_skip_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_MOVZ && src_b_i != '0) |=> !wr_en_o);

    assert_movn_take_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_MOVN && src_b_i != '0) |=> (wr_en_o && result_o == $past(src_a_i)));

    assert_movn_skip_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_MOVN && src_b_i == '0) |=> !wr_en_o);

    assert_bad_op_R10: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_MOVN) |=> (!wr_en_o && result_o == '0));
endmodule

bind set_cmp_cmov scm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o)
);

// File: tb/set_cmp_cmov_tb.sv
module set_cmp_cmov_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [3:0]    op;
    logic [DW-1:0] a, b, old;
    logic [IW-1:0] imm;
    logic          isel;
    logic [DW-1:0] res;
    logic          we;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    set_cmp_cmov #(.DATA_W(DW), .IMM_W(IW)) u_dut (
        .clk(clk), .rst(rst), .op_i(op), .src_a_i(a), .src_b_i(b),
        .imm_i(imm), .imm_sel_i(isel), .old_dst_i(old),
        .result_o(res), .wr_en_o(we)
    );

    function automatic logic [DW-1:0] corner(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h1234_5678;
            6: return 32'hFFFF_8000;
            default: return 32'h0000_7FFF;
        endcase
    endfunction

    function automatic logic [IW-1:0] imm_corner(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h8000;
            default: return 16'h7FFF;
        endcase
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] got_r, input logic got_w,
                         input logic [DW-1:0] exp_r, input logic exp_w);
        checks++;
        if (got_r !== exp_r || got_w !== exp_w) begin
            errors++;
            $display("FAIL %s: got result=%h we=%b, expected result=%h we=%b",
                     tag, got_r, got_w, exp_r, exp_w);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] opb, exp_r;
        logic          exp_w, hit;
        string         tag;

        rst = 1'b1; op = 4'd0; a = '0; b = '0; old = '0; imm = '0; isel = 1'b0;
        @(negedge clk);
        op = 4'd4; a = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R11 reset", res, we, '0, 1'b0);
        rst = 1'b0;

        for (int o = 0; o < 16; o++) begin
            for (int s = 0; s < 2; s++) begin
                for (int ia = 0; ia < 8; ia++) begin
                    for (int ib = 0; ib < 8; ib++) begin
                        for (int ii = 0; ii < 4; ii++) begin
                            op   = o[3:0];
                            isel = s[0];
                            a    = corner(ia);
                            b    = corner(ib);
                            imm  = imm_corner(ii);
                            old  = a ^ 32'h5A5A_0F0F ^ {16'h0, imm};
                            opb  = (s == 1) ? {{(DW-IW){imm[IW-1]}}, imm} : b;
                            hit  = 1'b0;
                            case (o)
                                0: begin hit = (a == opb); tag = "R2"; end
                                1: begin hit = (a != opb); tag = "R3"; end
                                2: begin hit = ($signed(a) < $signed(opb)); tag = "R4"; end
                                3: begin hit = (a < opb); tag = "R5"; end
                                4: tag = (s == 1) ? "R7 R9" : "R7";
                                5: tag = (s == 1) ? "R8 R9" : "R8";
                                default: tag = "R10";
                            endcase
                            if (o < 4) begin
                                exp_r = {31'b0, hit};
                                exp_w = 1'b1;
                                if (s == 1) tag = {tag, " R6"};
                            end else if (o == 4) begin
                                exp_w = (b == '0);
                                exp_r = exp_w ? a : old;
                            end else if (o == 5) begin
                                exp_w = (b != '0);
                                exp_r = exp_w ? a : old;
                            end else begin
                                exp_r = '0;
                                exp_w = 1'b0;
                            end
                            @(negedge clk);
                            check(tag, res, we, exp_r, exp_w);
                            if (o < 4) begin
                                checks++;
                                if (res[DW-1:1] !== '0 || we !== 1'b1) begin
                                    errors++;
                                    $display("FAIL R1: got result=%h we=%b, expected boolean with we=1",
                                             res, we);
                                end
                            end
                        end
                    end
                end
            end
        end

        op = 4'd4; a = 32'hCAFE_0001; b = '0; isel = 1'b0;
        @(negedge clk);
        check("R7 pre-reset", res, we, 32'hCAFE_0001, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R11 mid-run reset", res, we, '0, 1'b0);
        rst = 1'b0;
        op = 4'd1; a = 32'h5; b = 32'h6;
        @(negedge clk);
        check("R11 after reset", res, we, 32'h1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule